// File: doc/BRIEF.md
# CAN Message Buffer Filter and Transmit Arbiter

This block is the slot-management part of a CAN controller. It keeps a bank of message buffer slots, fifteen by default. Each slot is set up either to receive or to transmit. On the receive side it compares every frame the protocol engine delivers against the receive slots and picks the one that takes the frame. On the transmit side it always presents the pending transmit slot that should go out next. Bit timing, stuffing and the protocol engine itself sit outside this block.

Two acceptance masks are used. The main mask filters every slot except the last one. The basic mask belongs to the last slot alone, so that slot can act as a catch-all path for frames no other slot wants. A slot that sends a remote request can turn itself into a receiver once the request has gone out, so the answer lands in the same slot. A transmit slot marked for auto-reply is scheduled by itself when a remote frame with its identifier arrives.

Identifiers are carried in a 29-bit field. Standard frames use the low 11 bits, and the IDE flag keeps the two formats apart.

Top module: `mbx_filter_arb`

## Requirements
- R1: After reset every slot is a receiver (role_tx=0), and no slot is pending, full or overrun. tx_valid is 0.
- R2: A configuration write (cfg_we with cfg_idx below the slot count) sets that slot's role, identifier, IDE, remote-request flag, priority and auto-reply flag, and clears its pending, full and overrun bits on the next clock. A write wins over every other event on that slot in the same cycle.
- R3: A slot accepts a frame when every identifier bit whose mask bit is 0 equals its stored bit, and rx_ide equals its stored IDE. A mask bit of 1 means don't care. The last slot uses mask_basic and all other slots use mask_main. Only receive slots take frames.
- R4: rx_hit and rx_slot follow the inputs in the same cycle. When several receive slots accept a frame, the lowest index wins, so the last slot gets a frame only when no other slot accepts it.
- R5: A stored frame sets the slot's full bit on the next clock. If the slot was already full and rd_clr did not clear it in that cycle, the overrun bit is set too. Overrun stays set until the slot is reconfigured, and rd_clr clears full.
- R6: A tx_req bit sets pending only on a transmit slot. On a receive slot it has no effect.
- R7: tx_valid is 1 when any slot is pending. tx_slot is the pending slot with the largest cfg_prio value, and on a tie the lower index wins.
- R8: A tx_done pulse while tx_valid is 1 clears pending on the granted slot on the next clock, unless a new request or auto-reply for that slot arrives in the same cycle.
- R9: When a transmit slot whose remote-request flag is set finishes (tx_done on its grant), it becomes a receive slot and its pending bit clears.
- R10: A remote frame (rx_rtr=1) that an auto-reply transmit slot (remote-request flag clear) accepts sets pending on the lowest such slot, and rx_hit stays 0. A remote frame that no such slot accepts goes through the receive path like a data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Slot being configured |
| cfg_tx | input | 1 | Role: 1 transmit, 0 receive |
| cfg_id | input | 29 | Stored identifier |
| cfg_ide | input | 1 | Stored IDE (1 = extended) |
| cfg_rreq | input | 1 | Slot sends remote requests and switches to receive afterwards |
| cfg_prio | input | 4 | Transmit priority, larger wins |
| cfg_reply | input | 1 | Answer matching remote frames automatically |
| mask_main | input | 29 | Acceptance mask for all slots but the last |
| mask_basic | input | 29 | Acceptance mask for the last slot |
| tx_req | input | 15 | Per-slot transmit request pulses |
| rd_clr | input | 15 | Per-slot read acknowledge, clears full |
| rx_valid | input | 1 | A received frame is presented |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received IDE flag |
| rx_rtr | input | 1 | Received frame is a remote frame |
| tx_done | input | 1 | The granted slot finished transmitting |
| rx_hit | output | 1 | The presented frame is stored in a slot |
| rx_slot | output | 4 | Slot that stores the frame |
| tx_valid | output | 1 | A transmit slot is pending |
| tx_slot | output | 4 | Slot to transmit next |
| role_tx | output | 15 | Current role per slot |
| pend | output | 15 | Pending transmit per slot |
| full | output | 15 | Unread data per slot |
| ovr | output | 15 | Overrun per slot |

## Verification
The bench targets frames that several slots accept at once. A picker that favours the wrong end, or that lets the basic slot win early, shows up as a wrong rx_slot. It sends frames that differ only in IDE, or only in masked bits. A filter that ignores IDE or reads the mask with the wrong sense either stores a frame it should refuse or misses one it should take. Priority ties between two pending slots, a remote-request slot finishing, and a remote frame meeting an auto-reply slot test the tie-break, the role switch, and the rule that a consumed remote frame must not also raise rx_hit. Overrun is tested with a second store into a full slot, including stores that coincide with a read acknowledge or a reconfiguration.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
   typedef enum logic {
      ROLE_RX = 1'b0,
      ROLE_TX = 1'b1
   } role_e;

   // acceptance test shared by the match generators
   function automatic logic id_accept(input logic [63:0] frame_id,
                                      input logic [63:0] slot_id,
                                      input logic [63:0] mask,
                                      input logic frame_ide,
                                      input logic slot_ide);
      return (((frame_id ^ slot_id) & ~mask) == 64'd0) && (frame_ide == slot_ide);
   endfunction
endpackage

// File: rtl/mbx_match.sv
`timescale 1ns/1ps
module mbx_match #(
   parameter int NUM_SLOTS = 15,
   parameter int ID_W      = 29,
   parameter bit HAS_BASIC = 1'b1
) (
   input  logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id,
   input  logic [NUM_SLOTS-1:0]           slot_ide,
   input  logic [NUM_SLOTS-1:0]           slot_en,
   input  logic [ID_W-1:0]                mask_main,
   input  logic [ID_W-1:0]                mask_basic,
   input  logic [ID_W-1:0]                f_id,
   input  logic                           f_ide,
   output logic [NUM_SLOTS-1:0]           hit
);
   import mbx_pkg::*;

   localparam int LAST = NUM_SLOTS - 1;

   if (ID_W > 64) begin : g_bad_w
      $error("mbx_match: ID_W above 64 is not supported");
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic [ID_W-1:0] msk;
      if (HAS_BASIC && g == LAST) begin : g_basic
         assign msk = mask_basic;
      end else begin : g_main
         assign msk = mask_main;
      end
      assign hit[g] = slot_en[g] &&
                      id_accept(64'(f_id), 64'(slot_id[g]), 64'(msk), f_ide, slot_ide[g]);
   end
endmodule

// File: rtl/mbx_pick_low.sv
`timescale 1ns/1ps
module mbx_pick_low #(
   parameter int N = 15,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = W'(i);
         end
      end
   end
endmodule

// File: rtl/mbx_prio_arb.sv
`timescale 1ns/1ps
module mbx_prio_arb #(
   parameter int N      = 15,
   parameter int PRIO_W = 4,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]             req,
   input  logic [N-1:0][PRIO_W-1:0] prio,
   output logic                     gnt_valid,
   output logic [W-1:0]             gnt_idx
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      best      = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!gnt_valid || prio[i] > best)) begin
            gnt_valid = 1'b1;
            gnt_idx   = W'(i);
            best      = prio[i];
         end
      end
   end
endmodule

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
   parameter int ID_W   = 29,
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              wr_tx,
   input  logic [ID_W-1:0]   wr_id,
   input  logic              wr_ide,
   input  logic              wr_rreq,
   input  logic [PRIO_W-1:0] wr_prio,
   input  logic              wr_reply,
   input  logic              set_req,
   input  logic              clr_rd,
   input  logic              store,
   input  logic              reply_set,
   input  logic              sent,
   output logic              is_tx,
   output logic [ID_W-1:0]   s_id,
   output logic              s_ide,
   output logic              s_rreq,
   output logic [PRIO_W-1:0] s_prio,
   output logic              s_reply,
   output logic              s_pend,
   output logic              s_full,
   output logic              s_ovr
);
   import mbx_pkg::*;

   role_e role_q;
   assign is_tx = (role_q == ROLE_TX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         role_q  <= ROLE_RX;
         s_id    <= '0;
         s_ide   <= 1'b0;
         s_rreq  <= 1'b0;
         s_prio  <= '0;
         s_reply <= 1'b0;
         s_pend  <= 1'b0;
         s_full  <= 1'b0;
         s_ovr   <= 1'b0;
      end else if (wr) begin
         role_q  <= wr_tx ? ROLE_TX : ROLE_RX;
         s_id    <= wr_id;
         s_ide   <= wr_ide;
         s_rreq  <= wr_rreq;
         s_prio  <= wr_prio;
         s_reply <= wr_reply;
         s_pend  <= 1'b0;
         s_full  <= 1'b0;
         s_ovr   <= 1'b0;
      end else begin
         if (store && s_full && !clr_rd) s_ovr <= 1'b1;
         if (store)       s_full <= 1'b1;
         else if (clr_rd) s_full <= 1'b0;
         if (sent && s_rreq) begin
            role_q <= ROLE_RX;
            s_pend <= 1'b0;
         end else if ((set_req && is_tx) || reply_set) begin
            s_pend <= 1'b1;
         end else if (sent) begin
            s_pend <= 1'b0;
         end
      end
   end

   AST_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      store && !wr |=> s_full) else $error("store lost"); // R5
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      s_ovr && !wr |=> s_ovr) else $error("overrun dropped"); // R5
   AST_RX_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !is_tx && !s_pend && !wr && !reply_set |=> !s_pend) else $error("rx slot pending"); // R6
   AST_SENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sent && !wr && !(set_req && is_tx) && !reply_set |=> !s_pend) else $error("pend kept"); // R8
   AST_RREQ_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      sent && s_rreq && !wr |=> !is_tx) else $error("no role switch"); // R9
endmodule

// File: rtl/mbx_filter_arb.sv
`timescale 1ns/1ps
module mbx_filter_arb #(
   parameter int NUM_SLOTS = 15,
   parameter int ID_W      = 29,
   parameter int PRIO_W    = 4,
   parameter bit HAS_BASIC = 1'b1,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SLOT_W-1:0]    cfg_idx,
   input  logic                 cfg_tx,
   input  logic [ID_W-1:0]      cfg_id,
   input  logic                 cfg_ide,
   input  logic                 cfg_rreq,
   input  logic [PRIO_W-1:0]    cfg_prio,
   input  logic                 cfg_reply,
   input  logic [ID_W-1:0]      mask_main,
   input  logic [ID_W-1:0]      mask_basic,
   input  logic [NUM_SLOTS-1:0] tx_req,
   input  logic [NUM_SLOTS-1:0] rd_clr,
   input  logic                 rx_valid,
   input  logic [ID_W-1:0]      rx_id,
   input  logic                 rx_ide,
   input  logic                 rx_rtr,
   input  logic                 tx_done,
   output logic                 rx_hit,
   output logic [SLOT_W-1:0]    rx_slot,
   output logic                 tx_valid,
   output logic [SLOT_W-1:0]    tx_slot,
   output logic [NUM_SLOTS-1:0] role_tx,
   output logic [NUM_SLOTS-1:0] pend,
   output logic [NUM_SLOTS-1:0] full,
   output logic [NUM_SLOTS-1:0] ovr
);
   localparam int LAST = NUM_SLOTS - 1;

   if (NUM_SLOTS < 2 || NUM_SLOTS > 64) begin : g_bad_n
      $error("mbx_filter_arb: NUM_SLOTS must be 2..64");
   end
   if (ID_W < 11 || ID_W > 64) begin : g_bad_id
      $error("mbx_filter_arb: ID_W must be 11..64");
   end
   if (PRIO_W < 1) begin : g_bad_p
      $error("mbx_filter_arb: PRIO_W must be positive");
   end

   logic [NUM_SLOTS-1:0][ID_W-1:0]   s_id;
   logic [NUM_SLOTS-1:0][PRIO_W-1:0] s_prio;
   logic [NUM_SLOTS-1:0]             s_ide, s_rreq, s_reply;
   logic [NUM_SLOTS-1:0]             data_match, reply_match, reply_en;
   logic                             data_any, reply_any, rx_data, reply_go;
   logic [SLOT_W-1:0]                data_idx, reply_idx;

   assign reply_en = role_tx & s_reply & ~s_rreq;

   mbx_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .HAS_BASIC(HAS_BASIC)) u_match_rx (
      .slot_id(s_id), .slot_ide(s_ide), .slot_en(~role_tx),
      .mask_main(mask_main), .mask_basic(mask_basic),
      .f_id(rx_id), .f_ide(rx_ide), .hit(data_match));

   mbx_match #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .HAS_BASIC(HAS_BASIC)) u_match_rep (
      .slot_id(s_id), .slot_ide(s_ide), .slot_en(reply_en),
      .mask_main(mask_main), .mask_basic(mask_basic),
      .f_id(rx_id), .f_ide(rx_ide), .hit(reply_match));

   mbx_pick_low #(.N(NUM_SLOTS)) u_pick_rx (
      .vec(data_match), .any(data_any), .idx(data_idx));

   mbx_pick_low #(.N(NUM_SLOTS)) u_pick_rep (
      .vec(reply_match), .any(reply_any), .idx(reply_idx));

   mbx_prio_arb #(.N(NUM_SLOTS), .PRIO_W(PRIO_W)) u_arb (
      .req(pend & role_tx), .prio(s_prio), .gnt_valid(tx_valid), .gnt_idx(tx_slot));

   assign reply_go = rx_valid && rx_rtr && reply_any;
   assign rx_data  = rx_valid && !reply_go;
   assign rx_hit   = rx_data && data_any;
   assign rx_slot  = data_idx;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic wr_g, store_g, rep_g, sent_g;
      assign wr_g    = cfg_we && (cfg_idx == SLOT_W'(g));
      assign store_g = rx_hit && (rx_slot == SLOT_W'(g));
      assign rep_g   = reply_go && (reply_idx == SLOT_W'(g));
      assign sent_g  = tx_done && tx_valid && (tx_slot == SLOT_W'(g));

      mbx_slot #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_g), .wr_tx(cfg_tx), .wr_id(cfg_id), .wr_ide(cfg_ide),
         .wr_rreq(cfg_rreq), .wr_prio(cfg_prio), .wr_reply(cfg_reply),
         .set_req(tx_req[g]), .clr_rd(rd_clr[g]), .store(store_g),
         .reply_set(rep_g), .sent(sent_g),
         .is_tx(role_tx[g]), .s_id(s_id[g]), .s_ide(s_ide[g]), .s_rreq(s_rreq[g]),
         .s_prio(s_prio[g]), .s_reply(s_reply[g]),
         .s_pend(pend[g]), .s_full(full[g]), .s_ovr(ovr[g]));
   end

   AST_RX_ONLY_RX_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hit |-> !role_tx[rx_slot]) else $error("frame to tx slot"); // R3
   AST_BASIC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hit && rx_slot == SLOT_W'(LAST) |-> data_match[LAST-1:0] == '0) else $error("basic early"); // R4
   AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> pend[tx_slot] && role_tx[tx_slot]) else $error("bad grant"); // R7
   AST_VALID_IFF_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid == ((pend & role_tx) != '0)) else $error("tx_valid wrong"); // R7
   AST_REPLY_NO_RXHIT: assert property (@(posedge clk) disable iff (!rst_n)
      reply_go |-> !rx_hit) else $error("remote frame stored twice"); // R10
   AST_RESET_IDLE: assert property (@(posedge clk)
      $rose(rst_n) |-> pend == '0 && role_tx == '0) else $error("reset state"); // R1
endmodule

// File: tb/mbx_filter_arb_tb.sv
`timescale 1ns/1ps
module mbx_filter_arb_tb;
   localparam int NS = 15;
   localparam int IW = 29;
   localparam int PW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, cfg_tx = 0, cfg_ide = 0, cfg_rreq = 0, cfg_reply = 0;
   logic [3:0] cfg_idx = '0;
   logic [IW-1:0] cfg_id = '0, mask_main = '0, mask_basic = '0, rx_id = '0;
   logic [PW-1:0] cfg_prio = '0;
   logic [NS-1:0] tx_req = '0, rd_clr = '0;
   logic rx_valid = 0, rx_ide = 0, rx_rtr = 0, tx_done = 0;
   logic rx_hit, tx_valid;
   logic [3:0] rx_slot, tx_slot;
   logic [NS-1:0] role_tx, pend, full, ovr;

   always #2 clk = ~clk;

   mbx_filter_arb u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tx(cfg_tx),
      .cfg_id(cfg_id), .cfg_ide(cfg_ide), .cfg_rreq(cfg_rreq), .cfg_prio(cfg_prio),
      .cfg_reply(cfg_reply), .mask_main(mask_main), .mask_basic(mask_basic),
      .tx_req(tx_req), .rd_clr(rd_clr), .rx_valid(rx_valid), .rx_id(rx_id),
      .rx_ide(rx_ide), .rx_rtr(rx_rtr), .tx_done(tx_done), .rx_hit(rx_hit),
      .rx_slot(rx_slot), .tx_valid(tx_valid), .tx_slot(tx_slot), .role_tx(role_tx),
      .pend(pend), .full(full), .ovr(ovr));

   // behavioural reference state
   bit m_tx[NS], m_ide[NS], m_rreq[NS], m_reply[NS], m_pend[NS], m_full[NS], m_ovr[NS];
   int unsigned m_id[NS];
   int m_prio[NS];
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string tag, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit acc(int i);
      int unsigned msk = (i == NS - 1) ? mask_basic : mask_main;
      return (((rx_id ^ m_id[i]) & ~msk & 32'h1FFF_FFFF) == 0) && (rx_ide == m_ide[i]);
   endfunction

   function automatic logic [NS-1:0] pack(input bit a[NS]);
      logic [NS-1:0] v;
      for (int i = 0; i < NS; i++) v[i] = a[i];
      return v;
   endfunction

   // one clock: compare at negedge, advance the model, release pulses
   task automatic step();
      int rep = -1, dat = -1, txs = -1;
      bit rxd;
      @(negedge clk);
      for (int i = NS - 1; i >= 0; i--)
         if (m_tx[i] && m_reply[i] && !m_rreq[i] && acc(i)) rep = i;
      if (!(rx_valid && rx_rtr)) rep = -1;
      rxd = rx_valid && (rep < 0);
      for (int i = NS - 1; i >= 0; i--)
         if (!m_tx[i] && acc(i)) dat = i;
      if (!rxd) dat = -1;
      for (int i = 0; i < NS; i++)
         if (m_pend[i] && m_tx[i] && (txs < 0 || m_prio[i] > m_prio[txs])) txs = i;
      chk("R4 rx_hit", rx_hit, dat >= 0);
      if (dat >= 0) chk("R4 rx_slot", rx_slot, dat);
      chk("R7 tx_valid", tx_valid, txs >= 0);
      if (txs >= 0) chk("R7 tx_slot", tx_slot, txs);
      chk("R9 role_tx", role_tx, pack(m_tx));
      chk("R6 pend", pend, pack(m_pend));
      chk("R5 full", full, pack(m_full));
      chk("R5 ovr", ovr, pack(m_ovr));
      for (int i = 0; i < NS; i++) begin
         bit sent = tx_done && (txs == i);
         bit st = (dat == i);
         if (cfg_we && cfg_idx == i) begin
            m_tx[i] = cfg_tx; m_id[i] = cfg_id; m_ide[i] = cfg_ide; m_rreq[i] = cfg_rreq;
            m_prio[i] = cfg_prio; m_reply[i] = cfg_reply;
            m_pend[i] = 0; m_full[i] = 0; m_ovr[i] = 0;
         end else begin
            if (st && m_full[i] && !rd_clr[i]) m_ovr[i] = 1;
            if (st) m_full[i] = 1; else if (rd_clr[i]) m_full[i] = 0;
            if (sent && m_rreq[i]) begin m_tx[i] = 0; m_pend[i] = 0; end
            else if ((tx_req[i] && m_tx[i]) || rep == i) m_pend[i] = 1;
            else if (sent) m_pend[i] = 0;
         end
      end
      @(posedge clk);
      #1;
      cfg_we = 0; tx_req = '0; rd_clr = '0; rx_valid = 0; rx_rtr = 0; tx_done = 0;
   endtask

   task automatic cfg(int idx, bit tx, int unsigned id, bit ide, bit rr, int pr, bit rp);
      cfg_we = 1; cfg_idx = 4'(idx); cfg_tx = tx; cfg_id = IW'(id); cfg_ide = ide;
      cfg_rreq = rr; cfg_prio = PW'(pr); cfg_reply = rp;
      step();
   endtask

   task automatic frame(int unsigned id, bit ide, bit rtr);
      rx_valid = 1; rx_id = IW'(id); rx_ide = ide; rx_rtr = rtr;
      #0.5;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1 role_tx", role_tx, 0); chk("R1 pend", pend, 0);
      chk("R1 full", full, 0); chk("R1 ovr", ovr, 0); chk("R1 tx_valid", tx_valid, 0);
      @(posedge clk); #1;
      mask_main = '0; mask_basic = '1;
      cfg(0, 0, 'h100, 0, 0, 0, 0);
      cfg(1, 0, 'h100, 0, 0, 0, 0);
      cfg(5, 0, 'h1ABCDE, 1, 0, 0, 0);
      cfg(2, 1, 'h010, 0, 0, 3, 0);
      chk("R2 role slot2", role_tx[2], 1);
      cfg(3, 1, 'h011, 0, 0, 7, 0);
      cfg(4, 1, 'h012, 0, 0, 7, 0);
      cfg(6, 1, 'h0AA, 0, 1, 1, 0);
      cfg(7, 1, 'h222, 0, 0, 2, 1);
      frame('h100, 0, 0); chk("R4 lowest", rx_slot, 0); step();
      chk("R5 full0", full[0], 1);
      frame('h100, 0, 0); step();
      chk("R5 overrun0", ovr[0], 1);
      frame('h100, 1, 0); chk("R3 ide mismatch", rx_hit, 0); step();
      frame('h333, 0, 0); chk("R3 basic catch", rx_slot, 14); step();
      mask_main = 'h00F;
      frame('h10A, 0, 0); chk("R3 masked bits", rx_slot, 0); step();
      frame('h1ABCDE, 1, 0); chk("R3 extended", rx_slot, 5); step();
      tx_req = 15'b1; step();
      chk("R6 rx ignores req", pend[0], 0);
      tx_req = 15'b11100; step();
      chk("R7 prio tie", tx_slot, 3);
      tx_done = 1; step();
      chk("R8 done clears", pend[3], 0); chk("R7 next", tx_slot, 4);
      tx_done = 1; step(); chk("R7 low prio", tx_slot, 2);
      tx_done = 1; step(); chk("R8 empty", tx_valid, 0);
      tx_req = 15'b1 << 6; step(); chk("R7 rreq slot", tx_slot, 6);
      tx_done = 1; step(); chk("R9 switched", role_tx[6], 0);
      frame('h0AA, 0, 0); chk("R9 answer stored", rx_slot, 6); step();
      frame('h222, 0, 1); chk("R10 no rx_hit", rx_hit, 0); step();
      chk("R10 reply pending", pend[7], 1);
      frame('h2F0, 0, 1); chk("R10 remote to rx", rx_slot, 14); step();
      rd_clr = 15'b1; step(); chk("R5 read clears", full[0], 0);
      tx_done = 1; step();
      // mixed traffic
      for (int k = 0; k < 600; k++) begin
         cfg_we = ($urandom % 6) == 0; cfg_idx = 4'($urandom);
         cfg_tx = $urandom; cfg_id = IW'($urandom % 8); cfg_ide = ($urandom % 4) == 0;
         cfg_rreq = ($urandom % 3) == 0; cfg_prio = PW'($urandom % 4); cfg_reply = $urandom;
         if (k % 50 == 0) begin mask_main = IW'($urandom % 4); mask_basic = IW'($urandom % 8); end
         tx_req = NS'($urandom) & NS'($urandom); rd_clr = NS'($urandom) & NS'($urandom);
         rx_valid = $urandom; rx_id = IW'($urandom % 8); rx_ide = ($urandom % 4) == 0;
         rx_rtr = ($urandom % 3) == 0; tx_done = $urandom;
         step();
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule